// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block gathers up to eight level-sensitive interrupt lines and tracks them in three registers: pending requests, levels in service, and a mask. When a pending, unmasked request is allowed by the current priority state, it raises a single interrupt line to the processor. The processor answers with two acknowledge strobes. The first strobe moves the winning level from pending to in service. The second strobe returns a vector byte that names that level.

Priority is fixed by default, with level 0 highest. End-of-service commands can rotate the order so that a level just serviced drops to the bottom. A special mask mode lets any unmasked level interrupt, whether it sits above or below the levels in service. An automatic end-of-service option clears the in-service bit on the last acknowledge strobe, and can also rotate the order at that point. Software that does not use the acknowledge path can instead read a poll word, which both reports and services the winning level. A simple write/read register port carries the mask, the commands and a configuration word.

The register port has no back-pressure. A write is taken in the cycle its strobe is high. A read always answers one cycle later with a one-cycle valid. The vector output is a one-cycle valid pulse with no ready, because it only answers a strobe the processor issued itself.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After reset, the pending, in-service and mask registers are all zero and the interrupt output is low. Level 7 is the lowest priority, so level 0 is the highest. The vector base is zero, and automatic end-of-service, auto-rotate and special mask mode are all off.
- R2: A high line `irq_i[k]` at a clock edge sets pending bit k. The bit stays set after the line drops, and `int_o` is high from the next cycle when the request is allowed. Writing 1 to mask bit k (port address 1) keeps level k from raising `int_o`, and leaves its pending bit set.
- R3: On the first acknowledge strobe, the highest-priority allowed pending level gets its in-service bit set. Its pending bit is cleared, unless its line is still high.
- R4: On the second acknowledge strobe, `vec_valid_o` is high for exactly the following cycle. `vec_data_o` then carries the vector base in bits 7:3 and the serviced level in bits 2:0. If nothing was allowed at the first strobe, the level reported is 7 and no in-service bit changes.
- R5: With special mask mode off, a pending level raises `int_o` only when it has strictly higher priority than every level in service. Equal or lower levels wait.
- R6: A command byte has bits 4:3 = 00, bit 7 = rotate, bit 6 = specific, bit 5 = end, and bits 2:0 = level. 0x20 clears the highest-priority in-service bit. 0x60|L clears in-service bit L.
- R7: Command 0xA0 clears the highest-priority in-service bit and makes that level the lowest priority. For example, with levels 4 and 6 raised together, 4 is served first and then 6. Once 6 has been rotated down, level 7 outranks level 4.
- R8: Command 0xC0|L makes L the lowest priority without touching in-service bits. Command 0xE0|L clears in-service bit L and makes L the lowest priority.
- R9: A mode byte has bits 4:3 = 01. If its bit 6 is set, bit 5 becomes the special mask mode flag, so 0x68 turns the mode on and 0x48 turns it off. In this mode any pending level that is neither masked nor in service is allowed, whatever its priority.
- R10: A configuration write (address 2) loads the vector base from bits 7:3 and the automatic end-of-service flag from bit 0. With the flag set, the second acknowledge strobe clears the serviced in-service bit. Command 0x80 turns on auto-rotate, which also makes that level the lowest priority. Command 0x00 turns auto-rotate off.
- R11: A read of address 3 returns bit 7 = 1 and bits 2:0 = the winning level when an allowed request exists, and services that level as the first acknowledge does. Otherwise it returns 0x00.
- R12: A read at address 0, 1 or 2 returns pending, mask or in-service in the next cycle, with `rd_valid_o` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Level-sensitive interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 command, 1 mask, 2 configuration |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address: 0 pending, 1 mask, 2 in service, 3 poll |
| rd_data_o | output | 8 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | One-cycle read response valid |
| inta_i | input | 1 | Acknowledge strobe, one cycle per pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | One-cycle vector valid |
| vec_data_o | output | 8 | Vector byte |

## Verification
Some properties are checked on every cycle. The interrupt output only rises while an unmasked request is pending. The in-service register gains at most one bit per cycle, and only on an acknowledge strobe or a poll read. Each vector pulse lasts one cycle and follows an acknowledge strobe. Each read response follows a read request. Other behaviour shows only in the directed scenarios, which check actual values: which level wins under fixed, rotated and special-mask priority, that rotation moves the order, how automatic end-of-service clears bits, and the exact vector and poll words.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;
  // register port addresses
  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;
  localparam logic [1:0] ADDR_POLL = 2'd3;

  // command byte opcode in bits 4:3
  localparam logic [1:0] OP_SVC  = 2'b00;
  localparam logic [1:0] OP_MODE = 2'b01;

  typedef struct packed {
    logic rot;
    logic spec;
    logic eoi;
  } svc_cmd_t;
endpackage

// File: rtl/intr_prio_pick.sv
// Finds the highest-priority set bit of vec under a rotating order in which
// level (low + 1) mod N ranks first and level low ranks last.
module intr_prio_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low,
  output logic          found,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  always_comb begin
    found = 1'b0;
    lvl   = '0;
    rank  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      int k;
      k = (i + int'(low) + 1) % N;
      if (vec[k]) begin
        found = 1'b1;
        lvl   = LW'(k);
        rank  = LW'(i);
      end
    end
  end
endmodule

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs
  import intr_prio_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int LW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [N-1:0]     imr,
  output logic [DW-LW-1:0] vbase,
  output logic             aeoi,
  output logic             smm,
  output logic             svc_valid,
  output svc_cmd_t         svc_cmd,
  output logic [LW-1:0]    svc_lvl
);
  logic [1:0] opcode;
  logic       cmd_we;
  logic       mode_we;

  assign opcode    = wr_data[4:3];
  assign cmd_we    = wr_en && (wr_addr == ADDR_CMD);
  assign svc_valid = cmd_we && (opcode == OP_SVC);
  assign mode_we   = cmd_we && (opcode == OP_MODE) && wr_data[6];

  assign svc_cmd.rot  = wr_data[7];
  assign svc_cmd.spec = wr_data[6];
  assign svc_cmd.eoi  = wr_data[5];
  assign svc_lvl      = wr_data[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr   <= '0;
      vbase <= '0;
      aeoi  <= 1'b0;
      smm   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_MASK) imr <= wr_data[N-1:0];
      if (wr_en && wr_addr == ADDR_CFG) begin
        vbase <= wr_data[DW-1:LW];
        aeoi  <= wr_data[0];
      end
      if (mode_we) smm <= wr_data[5];
    end
  end
endmodule

// File: rtl/intr_service.sv
module intr_service
  import intr_prio_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int LW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq,
  input  logic [N-1:0]     imr,
  input  logic             smm,
  input  logic             aeoi,
  input  logic [DW-LW-1:0] vbase,
  input  logic             svc_valid,
  input  svc_cmd_t         svc_cmd,
  input  logic [LW-1:0]    svc_lvl,
  input  logic             inta,
  input  logic             poll_rd,
  output logic [N-1:0]     irr,
  output logic [N-1:0]     isr,
  output logic             grant,
  output logic [LW-1:0]    grant_lvl,
  output logic             vec_valid,
  output logic [DW-1:0]    vec_data
);
  localparam logic [LW-1:0] LAST = LW'(N - 1);

  logic [N-1:0]  irr_q, isr_q, irr_d, isr_d;
  logic [N-1:0]  req_eff, set_bits, clr_bits;
  logic [LW-1:0] low_q, low_d;
  logic          arot_q;
  logic          phase_q;
  logic [LW-1:0] sel_lvl_q;
  logic          sel_real_q;

  logic          rq_found, is_found;
  logic [LW-1:0] rq_lvl, rq_rank, is_lvl, is_rank;
  logic          ack_first, ack_last, take;
  logic [LW-1:0] eoi_tgt;
  logic          eoi_hit, auto_hit;

  // requests that compete: unmasked, and in special mask mode not in service
  assign req_eff = irr_q & ~imr & (smm ? ~isr_q : {N{1'b1}});

  intr_prio_pick #(.N(N), .LW(LW)) u_req_pick (
    .vec(req_eff), .low(low_q), .found(rq_found), .lvl(rq_lvl), .rank(rq_rank)
  );

  intr_prio_pick #(.N(N), .LW(LW)) u_isr_pick (
    .vec(isr_q), .low(low_q), .found(is_found), .lvl(is_lvl), .rank(is_rank)
  );

  assign grant     = rq_found && (smm || !is_found || (rq_rank < is_rank));
  assign grant_lvl = rq_lvl;

  assign ack_first = inta && !phase_q;
  assign ack_last  = inta && phase_q;
  assign take      = grant && (ack_first || poll_rd);
  assign set_bits  = take ? (N'(1) << rq_lvl) : '0;

  // end-of-service handling
  assign eoi_tgt  = svc_cmd.spec ? svc_lvl : is_lvl;
  assign eoi_hit  = svc_valid && svc_cmd.eoi && (svc_cmd.spec || is_found);
  assign auto_hit = ack_last && aeoi && sel_real_q;

  always_comb begin
    clr_bits = '0;
    if (eoi_hit)  clr_bits = clr_bits | (N'(1) << eoi_tgt);
    if (auto_hit) clr_bits = clr_bits | (N'(1) << sel_lvl_q);
  end

  always_comb begin
    low_d = low_q;
    if (auto_hit && arot_q) low_d = sel_lvl_q;
    if (eoi_hit && svc_cmd.rot) low_d = eoi_tgt;
    if (svc_valid && svc_cmd.rot && svc_cmd.spec && !svc_cmd.eoi) low_d = svc_lvl;
  end

  // per-level request and service bit update
  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign irr_d[g] = (irr_q[g] & ~set_bits[g]) | irq[g];
    assign isr_d[g] = (isr_q[g] | set_bits[g]) & ~clr_bits[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q      <= '0;
      isr_q      <= '0;
      low_q      <= LAST;
      arot_q     <= 1'b0;
      phase_q    <= 1'b0;
      sel_lvl_q  <= LAST;
      sel_real_q <= 1'b0;
      vec_valid  <= 1'b0;
      vec_data   <= '0;
    end else begin
      irr_q     <= irr_d;
      isr_q     <= isr_d;
      low_q     <= low_d;
      vec_valid <= ack_last;
      if (svc_valid && !svc_cmd.eoi && !svc_cmd.spec) arot_q <= svc_cmd.rot;
      if (ack_first) begin
        phase_q    <= 1'b1;
        sel_lvl_q  <= grant ? rq_lvl : LAST;
        sel_real_q <= grant;
      end
      if (ack_last) begin
        phase_q  <= 1'b0;
        vec_data <= {vbase, sel_lvl_q};
      end
    end
  end

  assign irr = irr_q;
  assign isr = isr_q;
endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl
  import intr_prio_pkg::*;
#(
  parameter int N_LVL = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] irq_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  input  logic [1:0]       rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  input  logic             inta_i,
  output logic             int_o,
  output logic             vec_valid_o,
  output logic [DW-1:0]    vec_data_o
);
  logic [N_LVL-1:0] imr_w, irr_w, isr_w;
  logic [DW-LW-1:0] vbase_w;
  logic             aeoi_w, smm_w, svc_valid_w;
  svc_cmd_t         svc_cmd_w;
  logic [LW-1:0]    svc_lvl_w;
  logic             grant_w;
  logic [LW-1:0]    grant_lvl_w;
  logic             poll_rd;
  logic [DW-1:0]    poll_word;

  assign poll_rd = rd_en_i && (rd_addr_i == ADDR_POLL);

  intr_cfg_regs #(.N(N_LVL), .DW(DW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .imr(imr_w), .vbase(vbase_w), .aeoi(aeoi_w), .smm(smm_w),
    .svc_valid(svc_valid_w), .svc_cmd(svc_cmd_w), .svc_lvl(svc_lvl_w)
  );

  intr_service #(.N(N_LVL), .DW(DW), .LW(LW)) u_svc (
    .clk(clk), .rst_n(rst_n),
    .irq(irq_i), .imr(imr_w), .smm(smm_w), .aeoi(aeoi_w), .vbase(vbase_w),
    .svc_valid(svc_valid_w), .svc_cmd(svc_cmd_w), .svc_lvl(svc_lvl_w),
    .inta(inta_i), .poll_rd(poll_rd),
    .irr(irr_w), .isr(isr_w), .grant(grant_w), .grant_lvl(grant_lvl_w),
    .vec_valid(vec_valid_o), .vec_data(vec_data_o)
  );

  assign int_o     = grant_w;
  assign poll_word = {grant_w, {(DW-1-LW){1'b0}}, (grant_w ? grant_lvl_w : {LW{1'b0}})};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        case (rd_addr_i)
          ADDR_CMD:  rd_data_o <= DW'(irr_w);
          ADDR_MASK: rd_data_o <= DW'(imr_w);
          ADDR_CFG:  rd_data_o <= DW'(isr_w);
          default:   rd_data_o <= poll_word;
        endcase
      end
    end
  end
endmodule

// File: rtl/intr_prio_chk.sv
module intr_prio_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inta,
  input logic         rd_en,
  input logic [1:0]   rd_addr,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr,
  input logic [N-1:0] imr,
  input logic         int_o,
  input logic         vec_valid,
  input logic         rd_valid
);
  // R2
  int_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr & ~imr) != '0));

  // R3
  isr_single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr & ~$past(isr)));

  // R3
  isr_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr)) != '0) |-> $past(inta || (rd_en && rd_addr == 2'd3)));

  // R4
  vec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  // R4
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta));

  // R12
  rd_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

bind intr_prio_ctrl intr_prio_chk #(.N(N_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta_i), .rd_en(rd_en_i), .rd_addr(rd_addr_i),
  .irr(irr_w), .isr(isr_w), .imr(imr_w), .int_o(int_o),
  .vec_valid(vec_valid_o), .rd_valid(rd_valid_o)
);

// File: tb/sim_intr_prio_ctrl.sv
`timescale 1ns/1ps
module sim_intr_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       inta = 1'b0;
  logic       int_o;
  logic       vec_valid;
  logic [7:0] vec_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  intr_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .inta_i(inta), .int_o(int_o), .vec_valid_o(vec_valid), .vec_data_o(vec_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq = '0; wr_en = 1'b0; rd_en = 1'b0; inta = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    v = rd_data;
    chk("R12 rd_valid", rd_valid, 1);
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0;
  endtask

  task automatic ack1();
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic ack2(output logic [7:0] v);
    ack1();
    ack1();
    v = vec_data;
    chk("R4 vec_valid", vec_valid, 1);
    @(negedge clk);
    chk("R4 vec_valid drop", vec_valid, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk("R1 int", int_o, 0);
    chk("R1 vec_valid", vec_valid, 0);
    rd(2'd0, v); chk("R1 irr", v, 8'h00);
    rd(2'd1, v); chk("R1 imr", v, 8'h00);
    rd(2'd2, v); chk("R1 isr", v, 8'h00);
    @(negedge clk);
    chk("R12 rd_valid idle", rd_valid, 0);
  endtask

  task automatic t_request_mask();
    logic [7:0] v;
    do_reset();
    pulse(8'h04);
    chk("R2 int raised", int_o, 1);
    rd(2'd0, v); chk("R2 irr latched", v, 8'h04);
    wr(2'd1, 8'h04);
    chk("R2 masked int", int_o, 0);
    rd(2'd1, v); chk("R2 imr read", v, 8'h04);
    rd(2'd0, v); chk("R2 irr kept under mask", v, 8'h04);
  endtask

  task automatic t_first_ack();
    logic [7:0] v;
    do_reset();
    pulse(8'h0C);
    ack1();
    rd(2'd0, v); chk("R3 irr after ack", v, 8'h08);
    rd(2'd2, v); chk("R3 isr after ack", v, 8'h04);
    ack1();
    chk("R4 vector level 2", vec_data, 8'h02);
  endtask

  task automatic t_spurious();
    logic [7:0] v;
    do_reset();
    ack2(v);
    chk("R4 spurious vector", v, 8'h07);
    rd(2'd2, v); chk("R4 spurious isr", v, 8'h00);
  endtask

  task automatic t_nested();
    logic [7:0] v;
    do_reset();
    pulse(8'h08);
    ack2(v); chk("R5 vector 3", v, 8'h03);
    pulse(8'h20);
    chk("R5 lower blocked", int_o, 0);
    pulse(8'h08);
    chk("R5 equal blocked", int_o, 0);
    pulse(8'h02);
    chk("R5 higher allowed", int_o, 1);
    ack2(v); chk("R5 nested vector 1", v, 8'h01);
    wr(2'd0, 8'h20);
    rd(2'd2, v); chk("R6 nonspecific eoi", v, 8'h08);
    chk("R6 int after eoi", int_o, 0);
    wr(2'd0, 8'h63);
    rd(2'd2, v); chk("R6 specific eoi", v, 8'h00);
    chk("R6 int after specific", int_o, 1);
  endtask

  task automatic t_rotate();
    logic [7:0] v;
    do_reset();
    pulse(8'h50);
    ack2(v); chk("R7 first served 4", v, 8'h04);
    chk("R7 int blocked", int_o, 0);
    wr(2'd0, 8'hA0);
    chk("R7 int after rotate", int_o, 1);
    ack2(v); chk("R7 then 6", v, 8'h06);
    wr(2'd0, 8'hA0);
    rd(2'd2, v); chk("R7 isr clear", v, 8'h00);
    pulse(8'h90);
    ack2(v); chk("R7 7 outranks 4", v, 8'h07);
  endtask

  task automatic t_set_prio();
    logic [7:0] v;
    do_reset();
    wr(2'd0, 8'hC2);
    pulse(8'h22);
    ack2(v); chk("R8 set priority picks 5", v, 8'h05);
    wr(2'd0, 8'hE5);
    rd(2'd2, v); chk("R8 specific rotate clears", v, 8'h00);
    pulse(8'h80);
    ack2(v); chk("R8 rotated picks 7", v, 8'h07);
  endtask

  task automatic t_smm();
    logic [7:0] v;
    do_reset();
    pulse(8'h04);
    ack2(v); chk("R9 vector 2", v, 8'h02);
    wr(2'd1, 8'h01);
    pulse(8'h41);
    chk("R9 nested blocks 6", int_o, 0);
    wr(2'd0, 8'h68);
    chk("R9 smm allows 6", int_o, 1);
    ack2(v); chk("R9 smm vector 6", v, 8'h06);
    chk("R9 masked 0 ignored", int_o, 0);
    rd(2'd2, v); chk("R9 isr", v, 8'h44);
    wr(2'd0, 8'h48);
    chk("R9 smm off", int_o, 0);
  endtask

  task automatic t_aeoi();
    logic [7:0] v;
    do_reset();
    wr(2'd2, 8'hA9);
    pulse(8'h08);
    ack2(v); chk("R10 vector base", v, 8'hAB);
    rd(2'd2, v); chk("R10 auto clear", v, 8'h00);
    wr(2'd0, 8'h80);
    pulse(8'h44);
    ack2(v); chk("R10 vector 2", v, 8'hAA);
    pulse(8'h02);
    ack2(v); chk("R10 auto rotate picks 6", v, 8'hAE);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    do_reset();
    pulse(8'h20);
    rd(2'd3, v); chk("R11 poll word", v, 8'h85);
    rd(2'd2, v); chk("R11 poll services", v, 8'h20);
    rd(2'd0, v); chk("R11 irr cleared", v, 8'h00);
    rd(2'd3, v); chk("R11 empty poll", v, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_request_mask();
    t_first_ack();
    t_spurious();
    t_nested();
    t_rotate();
    t_set_prio();
    t_smm();
    t_aeoi();
    t_poll();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule